// File: doc/BRIEF.md
# Cartridge Save-Memory Access Gate

This block sits on the main CPU bus and decides whether an access belongs to cartridge save memory. It decodes a save window that starts at 0x200000, gates reads and writes by a two-bit control register, and steers every write that it accepts either into an internal battery-backed byte array or out to a serial-EEPROM engine that lives elsewhere. The block does not implement the EEPROM protocol. It only routes the access and reports which kind of save memory the cartridge uses.

The kind of save memory is learned at run time. The first write that lands in the window marks the memory as detected. If that write targets one of the two bytes at the window base, the block switches to EEPROM mode, and the window shrinks to those two bytes. A byte read above the base pair, made while reads are enabled and before detection, fixes the memory as ordinary RAM instead. A sticky modified flag tells the system that the array needs saving. The flag rises only when a write really changes a stored byte, and a clear pulse drops it.

Every result appears one clock edge after the cycle in which the strobe is presented. This covers read data, the hit flag, the EEPROM write pulse and all the mode flags.

Top module: `savemem_gate`

## Requirements
- R1: After reset, EEPROM mode, detection and the modified flag are all low, reads and write-protect are disabled, and the window spans 0x200000 to 0x20FFFF. An in-window read then returns bus_hit=0 and bus_rdata=0.
- R2: A byte write to address 0xA130F1 loads read-enable from data bit 0 and write-protect from data bit 1. It leaves the detection and EEPROM-mode flags unchanged.
- R3: In RAM mode with read-enable set, an in-window read returns bus_hit=1 on the following cycle. A word read (bus_word=1) returns the even byte in bits [15:8] and the odd byte in [7:0]. A byte read returns the byte in [7:0] with [15:8] zero. With read-enable clear, or with the address outside the window, bus_hit and bus_rdata are 0.
- R4: A RAM-mode write in the window updates the array only while write-protect is clear. With write-protect set, the stored bytes are unchanged.
- R5: The modified flag rises only when an accepted array write changes at least one stored byte. It then stays high until dirty_clr is pulsed, and a change in the same cycle as dirty_clr wins over the clear.
- R6: The first write inside the window sets mem_detected. If that write is not to 0x200000 or 0x200001, the block stays in RAM mode, and a later write to the base pair does not enter EEPROM mode.
- R7: If the first in-window write targets 0x200000 or 0x200001, ee_mode and mem_detected rise and the window becomes 0x200000 to 0x200001 only. That write itself is not sent to the EEPROM port.
- R8: In EEPROM mode, an in-window write produces a one-cycle ee_wr pulse carrying ee_wdata (the bus data), ee_addr_lsb (address bit 0) and ee_word. It does not touch the array or the modified flag. An in-window read returns bus_hit=1 with {8'h00, ee_rdata} regardless of read-enable.
- R9: A byte read above 0x200001 in the window, made while read-enable is set and before detection, sets mem_detected in RAM mode. A following write to 0x200000 stays in RAM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access at the even address, 0 = byte access |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data; a byte write uses [7:0] |
| dirty_clr | input | 1 | Clears the modified flag |
| ee_rdata | input | 8 | Current data from the EEPROM engine |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| bus_hit | output | 1 | Save memory claimed the read |
| ee_wr | output | 1 | One-cycle write pulse to the EEPROM engine |
| ee_addr_lsb | output | 1 | Address bit 0 of that write |
| ee_word | output | 1 | That write was a word access |
| ee_wdata | output | 16 | Data of that write |
| ee_mode | output | 1 | Save memory is a serial EEPROM |
| mem_detected | output | 1 | Save-memory type has been decided |
| dirty | output | 1 | Array contents were modified |

## Verification
Each result is due exactly one rising edge after its strobe cycle: read data, hit, the EEPROM pulse, the mode flags and the modified flag are all registered once. The bench drives a strobe on a falling edge, removes it on the next falling edge, and samples the outputs at that same moment. That moment lies half a period after the edge that captured the access and before the next one. For the same reason, the single-cycle EEPROM pulse is observed in that window, and one cycle later its absence confirms it is a pulse.

// File: rtl/savemem_pkg.sv
package savemem_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef struct packed {
        logic rd_en;
        logic wr_prot;
    } ctrl_t;

    typedef struct packed {
        logic detected;
        logic ee_mode;
    } mode_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Byte address actually used for an access: word accesses align down.
    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                     input logic word);
        return word ? {a[ADDR_W-1:1], 1'b0} : a;
    endfunction

    // Lane selection: bit 0 = even byte, bit 1 = odd byte.
    function automatic logic [LANES-1:0] lane_select(input logic odd, input logic word);
        if (word) return '1;
        return odd ? LANES'(2'b10) : LANES'(2'b01);
    endfunction

endpackage

// File: rtl/savemem_decode.sv
module savemem_decode
    import savemem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h200000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hA130F1,
    parameter int                ROW_W     = 10
) (
    input  bus_req_t                  req,
    input  logic [ADDR_W-1:0]         range_end,
    input  ctrl_t                     ctrl,
    input  mode_t                     mode,
    output logic                      ctrl_wr,
    output logic                      first_wr,
    output logic                      ee_enter,
    output logic                      rd_detect,
    output logic                      ee_wr,
    output logic                      rd_claim,
    output logic [LANES-1:0]          lane_sel,
    output logic [LANES-1:0]          lane_we,
    output logic [ROW_W-1:0]          row,
    output logic [LANES-1:0][BYTE_W-1:0] lane_wd
);

    localparam logic [ADDR_W-1:0] BASE_PAIR_END = BASE_ADDR + ADDR_W'(1);

    logic [ADDR_W-1:0] acc_addr;
    logic              in_window;
    logic              wr_hit;
    logic              ram_wr;

    always_comb begin
        acc_addr  = align_addr(req.addr, req.word);
        in_window = (acc_addr >= BASE_ADDR) && (acc_addr <= range_end);
        row       = acc_addr[ROW_W:1];
        lane_sel  = lane_select(acc_addr[0], req.word);

        wr_hit    = req.wr && in_window;
        ram_wr    = wr_hit && !mode.ee_mode && !ctrl.wr_prot;
        lane_we   = ram_wr ? lane_sel : '0;
        ee_wr     = wr_hit && mode.ee_mode;

        lane_wd[0] = req.word ? req.wdata[DATA_W-1:BYTE_W] : req.wdata[BYTE_W-1:0];
        lane_wd[1] = req.wdata[BYTE_W-1:0];

        ctrl_wr   = req.wr && !req.word && (req.addr == CTRL_ADDR);
        first_wr  = wr_hit && !mode.detected;
        ee_enter  = first_wr && (acc_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

        rd_claim  = req.rd && in_window && (mode.ee_mode || ctrl.rd_en);
        rd_detect = req.rd && !req.word && in_window && ctrl.rd_en
                    && !mode.detected && (acc_addr > BASE_PAIR_END);
    end

endmodule

// File: rtl/savemem_mode.sv
module savemem_mode
    import savemem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'h200000,
    parameter logic [ADDR_W-1:0] DEFAULT_END = 24'h20FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [1:0]        ctrl_bits,
    input  logic              first_wr,
    input  logic              ee_enter,
    input  logic              rd_detect,
    input  logic              changed,
    input  logic              dirty_clr,
    output ctrl_t             ctrl,
    output mode_t             mode,
    output logic [ADDR_W-1:0] range_end,
    output logic              dirty
);

    localparam logic [ADDR_W-1:0] PAIR_END = BASE_ADDR + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            mode      <= '0;
            range_end <= DEFAULT_END;
            dirty     <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl.rd_en   <= ctrl_bits[0];
                ctrl.wr_prot <= ctrl_bits[1];
            end
            if (first_wr || rd_detect)
                mode.detected <= 1'b1;
            if (ee_enter) begin
                mode.ee_mode <= 1'b1;
                range_end    <= PAIR_END;
            end
            if (changed)
                dirty <= 1'b1;
            else if (dirty_clr)
                dirty <= 1'b0;
        end
    end

    p_detect_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        mode.detected |=> mode.detected);

    p_ee_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        mode.ee_mode |=> mode.ee_mode);

    p_ee_needs_detect_r7: assert property (@(posedge clk) disable iff (rst)
        mode.ee_mode |-> mode.detected);

    p_ee_window_r7: assert property (@(posedge clk) disable iff (rst)
        mode.ee_mode |-> (range_end == PAIR_END));

    p_dirty_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (dirty && !dirty_clr) |=> dirty);

endmodule

// File: rtl/savemem_lanes.sv
module savemem_lanes
    import savemem_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic                         clk,
    input  logic [ROW_W-1:0]             row,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][BYTE_W-1:0] lane_wd,
    output logic [LANES-1:0][BYTE_W-1:0] lane_rd,
    output logic                         changed
);

    localparam int DEPTH = 1 << ROW_W;

    logic [LANES-1:0] lane_diff;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[l])
                store[row] <= lane_wd[l];
        end

        assign lane_rd[l]   = store[row];
        assign lane_diff[l] = lane_we[l] && (store[row] != lane_wd[l]);
    end

    assign changed = |lane_diff;

endmodule

// File: rtl/savemem_gate.sv
module savemem_gate
    import savemem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'h200000,
    parameter logic [ADDR_W-1:0] DEFAULT_END = 24'h20FFFF,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 24'hA130F1,
    parameter int                ROW_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dirty_clr,
    input  logic [BYTE_W-1:0] ee_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    output logic              ee_wr,
    output logic              ee_addr_lsb,
    output logic              ee_word,
    output logic [DATA_W-1:0] ee_wdata,
    output logic              ee_mode,
    output logic              mem_detected,
    output logic              dirty
);

    bus_req_t                     req;
    ctrl_t                        ctrl;
    mode_t                        mode;
    logic [ADDR_W-1:0]            range_end;
    logic                         ctrl_wr, first_wr, ee_enter, rd_detect, ee_hit, rd_claim;
    logic [LANES-1:0]             lane_sel, lane_we;
    logic [ROW_W-1:0]             row;
    logic [LANES-1:0][BYTE_W-1:0] lane_wd, lane_rd;
    logic                         changed;
    logic [DATA_W-1:0]            rd_next;

    assign req = '{rd: bus_rd, wr: bus_wr, word: bus_word, addr: bus_addr, wdata: bus_wdata};

    savemem_decode #(
        .BASE_ADDR (BASE_ADDR),
        .CTRL_ADDR (CTRL_ADDR),
        .ROW_W     (ROW_W)
    ) u_decode (
        .req       (req),
        .range_end (range_end),
        .ctrl      (ctrl),
        .mode      (mode),
        .ctrl_wr   (ctrl_wr),
        .first_wr  (first_wr),
        .ee_enter  (ee_enter),
        .rd_detect (rd_detect),
        .ee_wr     (ee_hit),
        .rd_claim  (rd_claim),
        .lane_sel  (lane_sel),
        .lane_we   (lane_we),
        .row       (row),
        .lane_wd   (lane_wd)
    );

    savemem_mode #(
        .BASE_ADDR   (BASE_ADDR),
        .DEFAULT_END (DEFAULT_END)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (bus_wdata[1:0]),
        .first_wr  (first_wr),
        .ee_enter  (ee_enter),
        .rd_detect (rd_detect),
        .changed   (changed),
        .dirty_clr (dirty_clr),
        .ctrl      (ctrl),
        .mode      (mode),
        .range_end (range_end),
        .dirty     (dirty)
    );

    savemem_lanes #(
        .ROW_W (ROW_W)
    ) u_lanes (
        .clk     (clk),
        .row     (row),
        .lane_we (lane_we),
        .lane_wd (lane_wd),
        .lane_rd (lane_rd),
        .changed (changed)
    );

    always_comb begin
        rd_next = '0;
        if (rd_claim) begin
            if (mode.ee_mode)
                rd_next = {{(DATA_W-BYTE_W){1'b0}}, ee_rdata};
            else if (bus_word)
                rd_next = {lane_rd[0], lane_rd[1]};
            else
                rd_next = {{(DATA_W-BYTE_W){1'b0}}, lane_sel[1] ? lane_rd[1] : lane_rd[0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata   <= '0;
            bus_hit     <= 1'b0;
            ee_wr       <= 1'b0;
            ee_addr_lsb <= 1'b0;
            ee_word     <= 1'b0;
            ee_wdata    <= '0;
        end else begin
            bus_rdata <= rd_next;
            bus_hit   <= rd_claim;
            ee_wr     <= ee_hit;
            if (ee_hit) begin
                ee_addr_lsb <= bus_addr[0];
                ee_word     <= bus_word;
                ee_wdata    <= bus_wdata;
            end
        end
    end

    assign ee_mode      = mode.ee_mode;
    assign mem_detected = mode.detected;

    p_rd_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_hit);

    p_prot_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.wr_prot |-> (lane_we == '0));

    p_ee_no_array_r8: assert property (@(posedge clk) disable iff (rst)
        mode.ee_mode |-> (lane_we == '0));

    p_ee_pulse_mode_r8: assert property (@(posedge clk) disable iff (rst)
        ee_wr |-> ee_mode);

    p_ctrl_keeps_flags_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ($stable(ee_mode) && $stable(mem_detected)));

endmodule

// File: tb/tb_savemem_gate.sv
module tb_savemem_gate;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_rd, bus_wr, bus_word, dirty_clr;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [7:0]  ee_rdata;
    logic [15:0] bus_rdata, ee_wdata;
    logic        bus_hit, ee_wr, ee_addr_lsb, ee_word, ee_mode, mem_detected, dirty;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    savemem_gate dut (
        .clk, .rst, .bus_rd, .bus_wr, .bus_word, .bus_addr, .bus_wdata, .dirty_clr,
        .ee_rdata, .bus_rdata, .bus_hit, .ee_wr, .ee_addr_lsb, .ee_word, .ee_wdata,
        .ee_mode, .mem_detected, .dirty
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_word = 0; dirty_clr = 0;
        bus_addr = '0; bus_wdata = '0; ee_rdata = 8'h00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_op(input logic rd, input logic wr, input logic word,
                          input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        bus_op(1'b0, 1'b1, 1'b0, 24'hA130F1, {8'h00, v});
    endtask

    task automatic pulse_clr();
        @(negedge clk); dirty_clr = 1'b1;
        @(negedge clk); dirty_clr = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1", "ee_mode", ee_mode, 0);
        check("R1", "detected", mem_detected, 0);
        check("R1", "dirty", dirty, 0);
        bus_op(1, 0, 1, 24'h200010, 0);
        check("R1", "hit", bus_hit, 0);
        check("R1", "rdata", bus_rdata, 0);
    endtask

    task automatic t_ctrl();
        do_reset();
        set_ctrl(8'hFD);
        check("R2", "detected kept", mem_detected, 0);
        check("R2", "ee kept", ee_mode, 0);
        bus_op(1, 0, 0, 24'h200010, 0);
        check("R2", "read enabled", bus_hit, 1);
        set_ctrl(8'hFE);
        bus_op(1, 0, 0, 24'h200010, 0);
        check("R3", "read disabled hit", bus_hit, 0);
        check("R3", "read disabled data", bus_rdata, 0);
    endtask

    task automatic t_ram();
        do_reset();
        set_ctrl(8'h01);
        bus_op(0, 1, 1, 24'h200010, 16'hA55A);
        check("R6", "detected after first write", mem_detected, 1);
        check("R6", "ram mode", ee_mode, 0);
        bus_op(1, 0, 1, 24'h200010, 0);
        check("R3", "word hit", bus_hit, 1);
        check("R3", "word data", bus_rdata, 16'hA55A);
        bus_op(1, 0, 0, 24'h200011, 0);
        check("R3", "odd byte", bus_rdata, 16'h005A);
        bus_op(1, 0, 0, 24'h200010, 0);
        check("R3", "even byte", bus_rdata, 16'h00A5);
        pulse_clr();
        check("R5", "cleared", dirty, 0);
        bus_op(0, 1, 0, 24'h200011, 16'h005A);
        check("R5", "same byte no dirty", dirty, 0);
        bus_op(0, 1, 0, 24'h200011, 16'h0077);
        check("R5", "changed byte dirty", dirty, 1);
        @(negedge clk);
        check("R5", "sticky", dirty, 1);
        pulse_clr();
        @(negedge clk);
        bus_wr = 1; bus_word = 0; bus_addr = 24'h200011; bus_wdata = 16'h0099; dirty_clr = 1;
        @(negedge clk);
        bus_wr = 0; dirty_clr = 0;
        check("R5", "set beats clear", dirty, 1);
        set_ctrl(8'h03);
        bus_op(0, 1, 0, 24'h200011, 16'h0011);
        bus_op(1, 0, 0, 24'h200011, 0);
        check("R4", "protected byte", bus_rdata, 16'h0099);
        set_ctrl(8'h01);
        bus_op(0, 1, 0, 24'h20FFFF, 16'h003C);
        bus_op(1, 0, 0, 24'h20FFFF, 0);
        check("R3", "window end hit", bus_hit, 1);
        check("R4", "window end data", bus_rdata, 16'h003C);
        bus_op(1, 0, 0, 24'h210000, 0);
        check("R3", "past window", bus_hit, 0);
        bus_op(0, 1, 0, 24'h200000, 16'h0012);
        check("R6", "base write stays ram", ee_mode, 0);
        bus_op(1, 0, 0, 24'h200000, 0);
        check("R6", "base byte in array", bus_rdata, 16'h0012);
    endtask

    task automatic t_eeprom();
        do_reset();
        set_ctrl(8'h01);
        bus_op(0, 1, 0, 24'h200001, 16'h0042);
        check("R7", "ee mode", ee_mode, 1);
        check("R7", "detected", mem_detected, 1);
        check("R7", "first write not on ee port", ee_wr, 0);
        pulse_clr();
        bus_op(0, 1, 0, 24'h200000, 16'h0009);
        check("R8", "ee pulse", ee_wr, 1);
        check("R8", "ee data", ee_wdata, 16'h0009);
        check("R8", "ee lsb", ee_addr_lsb, 0);
        check("R8", "ee word", ee_word, 0);
        check("R8", "dirty untouched", dirty, 0);
        @(negedge clk);
        check("R8", "pulse one cycle", ee_wr, 0);
        bus_op(0, 1, 1, 24'h200000, 16'hBEEF);
        check("R8", "ee word pulse", ee_wr, 1);
        check("R8", "ee word flag", ee_word, 1);
        check("R8", "ee word data", ee_wdata, 16'hBEEF);
        bus_op(0, 1, 0, 24'h200004, 16'h0001);
        check("R7", "outside shrunk window", ee_wr, 0);
        ee_rdata = 8'hC3;
        set_ctrl(8'h00);
        bus_op(1, 0, 0, 24'h200001, 0);
        check("R8", "ee read hit", bus_hit, 1);
        check("R8", "ee read data", bus_rdata, 16'h00C3);
        bus_op(1, 0, 0, 24'h200002, 0);
        check("R7", "shrunk window read", bus_hit, 0);
    endtask

    task automatic t_read_detect();
        do_reset();
        set_ctrl(8'h01);
        bus_op(1, 0, 0, 24'h200001, 0);
        check("R9", "base pair read no detect", mem_detected, 0);
        bus_op(1, 0, 0, 24'h200100, 0);
        check("R9", "read detect", mem_detected, 1);
        check("R9", "still ram", ee_mode, 0);
        bus_op(0, 1, 0, 24'h200000, 16'h0012);
        check("R9", "base write stays ram", ee_mode, 0);
        bus_op(1, 0, 0, 24'h200000, 0);
        check("R9", "base byte readback", bus_rdata, 16'h0012);
    endtask

    initial begin
        t_reset_state();
        t_ctrl();
        t_ram();
        t_eeprom();
        t_read_detect();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule